// File: doc/BRIEF.md
# Paired Gather Flow Coalescer

This block turns one vector gather request into a stream of cache-read flows. The request carries eight 64-bit element addresses, one for each 8-byte lane of a 512-bit destination, together with a per-lane predicate. Each cycle the block issues one flow. A flow can serve two active lanes when their addresses fall inside the same 128-byte aligned block. A lane with no partner in its block is served by a flow of its own. Pairing is decided by address, not by how close two lanes sit in the register.

The cache side answers a flow with up to two 8-byte words. Each word carries back the lane tag it was issued with, and the block writes it into that lane of the result. Lanes whose predicate is clear never produce a flow and read back as zero. A one-cycle done pulse marks the point where every active lane has been written. A new request is taken only while the block is idle.

Top module: `gather_pair_coalescer`

## Requirements
- R1: A lane whose predicate bit is 0 appears in no flow tag, and its 64-bit result lane reads zero after done.
- R2: Two lanes share one flow only if address bits [63:7] of both lanes are equal; lanes in neighbouring 128-byte blocks are never paired.
- R3: Each flow's primary lane (tag0) is the lowest-index lane still unissued. Its secondary lane (tag1) is the lowest-index other unissued active lane in the same block, whatever their index distance.
- R4: A lane with no unissued partner in its block is issued alone, with the tag1 valid bit at 0.
- R5: Flows come out on consecutive cycles, starting the cycle after acceptance. Eight active lanes in one block take 4 flows, and eight lanes in eight distinct blocks take 8 flows.
- R6: A tag is 4 bits: bit 3 is the valid bit and bits [2:0] are the lane index. flow_addr is the full address of the primary lane, and flow_sec_off is bits [6:0] of the secondary lane's address.
- R7: A response word with a valid tag is written into the lane named by that tag. Lane i of result_data occupies bits [64*i+63:64*i].
- R8: done is high for exactly one cycle, the cycle after the one in which the last outstanding lane was written. With an all-zero predicate, done rises in the second cycle after acceptance.
- R9: req_ready is high only while idle. A request presented while busy is ignored and changes neither flows nor results.
- R10: A response word whose tag valid bit is 0 writes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | 512 | Eight 64-bit element addresses, lane i at [64*i+63:64*i] |
| req_pred | input | 8 | Per-lane active mask |
| flow_valid | output | 1 | A cache-read flow is issued this cycle |
| flow_addr | output | 64 | Full address of the primary lane |
| flow_sec_off | output | 7 | Byte offset of the secondary lane within the block |
| flow_tag0 | output | 4 | Primary lane tag {valid, index} |
| flow_tag1 | output | 4 | Secondary lane tag {valid, index} |
| rsp_valid | input | 1 | Response words present |
| rsp_tag0 | input | 4 | Tag for rsp_data0 |
| rsp_tag1 | input | 4 | Tag for rsp_data1 |
| rsp_data0 | input | 64 | First returned element |
| rsp_data1 | input | 64 | Second returned element |
| result_data | output | 512 | Assembled destination register |
| done | output | 1 | One-cycle pulse when all active lanes are filled |

## Verification
The bench targets pairs of lanes that sit far apart in the register but share a block. A coalescer that only paired neighbouring lanes would issue too many flows there and fail the flow count. Addresses on either side of a 128-byte boundary catch a block compare that uses too few address bits, because such a design would pair lanes that must stay apart. Inactive lanes placed in the same block as active ones expose a design that pairs or writes masked lanes. Single-element flows return a junk word under an invalid tag, so a store that ignores the tag valid bit corrupts lane 0. The bench also checks the done cycle exactly, holds a second request high during a busy gather, and mixes these cases with random gathers drawn from a few shared blocks.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int GPC_LANES       = 8;
  localparam int GPC_ADDR_W      = 64;
  localparam int GPC_ELEM_BYTES  = 8;
  localparam int GPC_BLOCK_BYTES = 128;

  typedef enum logic {
    GPC_IDLE = 1'b0,
    GPC_RUN  = 1'b1
  } gpc_state_e;
endpackage

// File: rtl/gpc_pair_pick.sv
module gpc_pair_pick #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 7,
  parameter int IDX_W  = 3
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic                    prim_vld,
  output logic [IDX_W-1:0]        prim_idx,
  output logic [ADDR_W-1:0]       prim_addr,
  output logic                    sec_vld,
  output logic [IDX_W-1:0]        sec_idx,
  output logic [ADDR_W-1:0]       sec_addr
);
  localparam int BLK_W = ADDR_W - OFF_W;

  function automatic logic [IDX_W-1:0] lowest_idx(input logic [LANES-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [LANES-1:0] partner;

  assign prim_vld  = |pend;
  assign prim_idx  = lowest_idx(pend);
  assign prim_addr = addr_flat[prim_idx*ADDR_W +: ADDR_W];

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign partner[g] = pend[g] && (IDX_W'(g) != prim_idx) &&
                        (block_of(addr_flat[g*ADDR_W +: ADDR_W]) == block_of(prim_addr));
  end

  assign sec_vld  = |partner;
  assign sec_idx  = lowest_idx(partner);
  assign sec_addr = addr_flat[sec_idx*ADDR_W +: ADDR_W];
endmodule

// File: rtl/gpc_issue_ctrl.sv
module gpc_issue_ctrl
  import gpc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LANES-1:0] req_pred,
  input  logic             prim_vld,
  input  logic [IDX_W-1:0] prim_idx,
  input  logic             sec_vld,
  input  logic [IDX_W-1:0] sec_idx,
  input  logic             waiting_none,
  output logic             busy,
  output logic             req_fire,
  output logic [LANES-1:0] pend,
  output logic             done
);
  function automatic logic [LANES-1:0] lane_bit(input logic [IDX_W-1:0] idx, input logic en);
    logic [LANES-1:0] r;
    r = '0;
    if (en) r[idx] = 1'b1;
    return r;
  endfunction

  gpc_state_e       state_q;
  logic [LANES-1:0] issue_mask;
  logic             finish_now;

  assign busy       = (state_q == GPC_RUN);
  assign req_fire   = req_valid && !busy;
  assign issue_mask = lane_bit(prim_idx, prim_vld) | lane_bit(sec_idx, sec_vld);
  assign finish_now = busy && !prim_vld && waiting_none;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GPC_IDLE;
      pend    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req_fire) begin
        state_q <= GPC_RUN;
        pend    <= req_pred;
      end else if (busy) begin
        if (prim_vld) begin
          pend <= pend & ~issue_mask;
        end else if (finish_now) begin
          state_q <= GPC_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end

  // R8: done never lasts two cycles
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a gather starts only from a presented request
  assert_start_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R5: each flow retires one or two pending lanes
  assert_flow_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prim_vld) |=>
      ($countones(pend) == $countones($past(pend)) - 1 - int'($past(sec_vld))));
endmodule

// File: rtl/gpc_lane_store.sv
module gpc_lane_store #(
  parameter int LANES  = 8,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES-1:0]        load_pred,
  input  logic                    rsp_valid,
  input  logic [IDX_W:0]          rsp_tag0,
  input  logic [IDX_W:0]          rsp_tag1,
  input  logic [DATA_W-1:0]       rsp_data0,
  input  logic [DATA_W-1:0]       rsp_data1,
  output logic [LANES*DATA_W-1:0] result_flat,
  output logic                    waiting_none
);
  function automatic logic tag_hits(input logic [IDX_W:0] tag, input int lane);
    return tag[IDX_W] && (tag[IDX_W-1:0] == IDX_W'(lane));
  endfunction

  logic [LANES-1:0] waiting_q;
  logic [LANES-1:0] hit0, hit1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;

    assign hit0[g] = rsp_valid && tag_hits(rsp_tag0, g);
    assign hit1[g] = rsp_valid && tag_hits(rsp_tag1, g);

    always_ff @(posedge clk) begin
      if (!rst_n)       lane_q <= '0;
      else if (load)    lane_q <= '0;
      else if (hit0[g]) lane_q <= rsp_data0;
      else if (hit1[g]) lane_q <= rsp_data1;
    end

    assign result_flat[g*DATA_W +: DATA_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    waiting_q <= '0;
    else if (load) waiting_q <= load_pred;
    else           waiting_q <= waiting_q & ~(hit0 | hit1);
  end

  assign waiting_none = (waiting_q == '0);

  // R7: a tagged word clears its lane's outstanding bit
  assert_tag_fills_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tag0[IDX_W] && !load) |=> !waiting_q[$past(rsp_tag0[IDX_W-1:0])]);

  // R10: untagged words leave every lane untouched
  assert_invalid_tag_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(rsp_valid && (rsp_tag0[IDX_W] || rsp_tag1[IDX_W]))) |=> $stable(result_flat));
endmodule

// File: rtl/gather_pair_coalescer.sv
module gather_pair_coalescer
  import gpc_pkg::*;
#(
  parameter int LANES       = GPC_LANES,
  parameter int ADDR_W      = GPC_ADDR_W,
  parameter int ELEM_BYTES  = GPC_ELEM_BYTES,
  parameter int BLOCK_BYTES = GPC_BLOCK_BYTES
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [LANES*ADDR_W-1:0]         req_addr,
  input  logic [LANES-1:0]                req_pred,
  output logic                            flow_valid,
  output logic [ADDR_W-1:0]               flow_addr,
  output logic [$clog2(BLOCK_BYTES)-1:0]  flow_sec_off,
  output logic [$clog2(LANES):0]          flow_tag0,
  output logic [$clog2(LANES):0]          flow_tag1,
  input  logic                            rsp_valid,
  input  logic [$clog2(LANES):0]          rsp_tag0,
  input  logic [$clog2(LANES):0]          rsp_tag1,
  input  logic [ELEM_BYTES*8-1:0]         rsp_data0,
  input  logic [ELEM_BYTES*8-1:0]         rsp_data1,
  output logic [LANES*ELEM_BYTES*8-1:0]   result_data,
  output logic                            done
);
  localparam int IDX_W  = $clog2(LANES);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int DATA_W = ELEM_BYTES * 8;

  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend;
  logic                    busy, req_fire, waiting_none;
  logic                    prim_vld, sec_vld;
  logic [IDX_W-1:0]        prim_idx, sec_idx;
  logic [ADDR_W-1:0]       prim_addr, sec_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (req_fire) addr_q <= req_addr;
  end

  gpc_pair_pick #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .addr_flat(addr_q),
    .prim_vld(prim_vld), .prim_idx(prim_idx), .prim_addr(prim_addr),
    .sec_vld(sec_vld), .sec_idx(sec_idx), .sec_addr(sec_addr)
  );

  gpc_issue_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pred(req_pred),
    .prim_vld(prim_vld), .prim_idx(prim_idx), .sec_vld(sec_vld), .sec_idx(sec_idx),
    .waiting_none(waiting_none), .busy(busy), .req_fire(req_fire),
    .pend(pend), .done(done)
  );

  gpc_lane_store #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .load_pred(req_pred),
    .rsp_valid(rsp_valid), .rsp_tag0(rsp_tag0), .rsp_tag1(rsp_tag1),
    .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
    .result_flat(result_data), .waiting_none(waiting_none)
  );

  assign req_ready    = !busy;
  assign flow_valid   = busy && prim_vld;
  assign flow_addr    = prim_addr;
  assign flow_sec_off = sec_vld ? sec_addr[OFF_W-1:0] : '0;
  assign flow_tag0    = {flow_valid, prim_idx};
  assign flow_tag1    = {flow_valid && sec_vld, sec_vld ? sec_idx : '0};

  // R2: a paired lane's stored address lies in the primary's block
  assert_pair_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_valid && flow_tag1[IDX_W]) |->
      (addr_q[flow_tag1[IDX_W-1:0]*ADDR_W + OFF_W +: ADDR_W-OFF_W] == flow_addr[ADDR_W-1:OFF_W]));

  // R3: the two tags of one flow name different lanes
  assert_lanes_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_valid && flow_tag1[IDX_W]) |-> (flow_tag1[IDX_W-1:0] != flow_tag0[IDX_W-1:0]));

  // R9: no flow comes out while the block reports itself idle
  assert_no_flow_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flow_valid |-> !req_ready);
endmodule

// File: tb/gather_pair_coalescer_bench.sv
`timescale 1ns/1ps
module gather_pair_coalescer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [511:0] req_addr = '0;
  logic [7:0]   req_pred = '0;
  logic         flow_valid;
  logic [63:0]  flow_addr;
  logic [6:0]   flow_sec_off;
  logic [3:0]   flow_tag0, flow_tag1;
  logic         rsp_valid = 1'b0;
  logic [3:0]   rsp_tag0 = '0, rsp_tag1 = '0;
  logic [63:0]  rsp_data0 = '0, rsp_data1 = '0;
  logic [511:0] result_data;
  logic         done;

  always #2.5 clk = ~clk;

  gather_pair_coalescer u_gather_pair_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_pred(req_pred), .flow_valid(flow_valid),
    .flow_addr(flow_addr), .flow_sec_off(flow_sec_off), .flow_tag0(flow_tag0),
    .flow_tag1(flow_tag1), .rsp_valid(rsp_valid), .rsp_tag0(rsp_tag0),
    .rsp_tag1(rsp_tag1), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
    .result_data(result_data), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc_total = 0;

  logic [63:0] ga [8];
  logic [7:0]  gp;
  int          ex_p [8];
  int          ex_s [8];
  bit          ex_sv [8];
  int          ex_n;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0], ~a[31:0]} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  // Expected flow list: walk lanes upward, give each unclaimed active lane
  // the next unclaimed active lane above it that shares address bits [63:7].
  task automatic plan_flows();
    bit taken [8];
    for (int i = 0; i < 8; i++) taken[i] = 0;
    ex_n = 0;
    for (int i = 0; i < 8; i++) begin
      if (gp[i] && !taken[i]) begin
        taken[i] = 1;
        ex_p[ex_n] = i;
        ex_sv[ex_n] = 0;
        ex_s[ex_n] = 0;
        for (int j = i + 1; j < 8; j++) begin
          if (!ex_sv[ex_n] && gp[j] && !taken[j] && (ga[j] >> 7) == (ga[i] >> 7)) begin
            taken[j] = 1;
            ex_sv[ex_n] = 1;
            ex_s[ex_n] = j;
          end
        end
        ex_n++;
      end
    end
  endtask

  // Runs one gather. Starts and ends at a falling edge.
  task automatic run_gather(input string name, input bit hold_busy, input int want_flows);
    int  fidx = 0;
    int  last = -1;
    bit  seen = 0;
    logic [63:0] snap_expect [8];
    plan_flows();
    if (want_flows >= 0)
      chk(ex_n == want_flows, {name, " R5 planned flows"}, 64'(ex_n), 64'(want_flows));
    for (int i = 0; i < 8; i++) begin
      req_addr[i*64 +: 64] = ga[i];
      snap_expect[i] = gp[i] ? mem_word(ga[i]) : 64'd0;
    end
    req_pred = gp;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, {name, " R9 ready when idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    for (int c = 0; c < 40; c++) begin
      if (hold_busy) begin
        req_valid = 1'b1;
        req_pred = 8'hFF;
        for (int i = 0; i < 8; i++) req_addr[i*64 +: 64] = 64'hF000_0000_0000_0000 + 64'(i) * 64'h1000;
      end else begin
        req_valid = 1'b0;
      end
      rsp_valid = 1'b0;
      if (done) begin
        req_valid = 1'b0;
        seen = 1;
        chk(c == last + 2, {name, " R8 done cycle"}, 64'(c), 64'(last + 2));
        break;
      end
      if (hold_busy)
        chk(req_ready == 1'b0, {name, " R9 not ready while busy"}, 64'(req_ready), 64'd0);
      if (flow_valid) begin
        if (fidx < ex_n) begin
          chk(flow_tag0 == {1'b1, 3'(ex_p[fidx])}, {name, " R3 primary tag"}, 64'(flow_tag0), 64'({1'b1, 3'(ex_p[fidx])}));
          chk(flow_addr == ga[ex_p[fidx]], {name, " R6 flow address"}, flow_addr, ga[ex_p[fidx]]);
          if (ex_sv[fidx]) begin
            chk(flow_tag1 == {1'b1, 3'(ex_s[fidx])}, {name, " R3 secondary tag"}, 64'(flow_tag1), 64'({1'b1, 3'(ex_s[fidx])}));
            chk(flow_sec_off == ga[ex_s[fidx]][6:0], {name, " R6 secondary offset"}, 64'(flow_sec_off), 64'(ga[ex_s[fidx]][6:0]));
          end else begin
            chk(flow_tag1[3] == 1'b0, {name, " R4 single flow"}, 64'(flow_tag1), 64'd0);
          end
        end
        chk(c == fidx, {name, " R5 back-to-back flows"}, 64'(c), 64'(fidx));
        rsp_valid = 1'b1;
        rsp_tag0  = flow_tag0;
        rsp_tag1  = flow_tag1;
        rsp_data0 = mem_word(ga[flow_tag0[2:0]]);
        // an untagged word carries junk that must land nowhere (R10)
        rsp_data1 = flow_tag1[3] ? mem_word(ga[flow_tag1[2:0]]) : 64'hDEAD_BEEF_BAD0_0BAD;
        fidx++;
        last = c;
      end else if (c == last + 1) begin
        rsp_valid = 1'b1;
        rsp_tag0  = 4'b0000;
        rsp_tag1  = 4'b0001;
        rsp_data0 = 64'hBAD0_BAD0_BAD0_BAD0;
        rsp_data1 = 64'hBAD1_BAD1_BAD1_BAD1;
      end
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    req_valid = 1'b0;
    chk(seen, {name, " R8 done seen"}, 64'(seen), 64'd1);
    chk(fidx == ex_n, {name, " R5 flow count"}, 64'(fidx), 64'(ex_n));
    for (int i = 0; i < 8; i++) begin
      if (gp[i])
        chk(result_data[i*64 +: 64] == snap_expect[i], {name, " R7 lane data"}, result_data[i*64 +: 64], snap_expect[i]);
      else
        chk(result_data[i*64 +: 64] == 64'd0, {name, " R1 inactive lane zero"}, result_data[i*64 +: 64], 64'd0);
    end
    @(negedge clk);
    chk(done == 1'b0, {name, " R8 single pulse"}, 64'(done), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc_total);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
    chk(flow_valid == 1'b0, "R5 reset no flow", 64'(flow_valid), 64'd0);
    chk(done == 1'b0, "R8 reset done low", 64'(done), 64'd0);
    chk(result_data == '0, "R1 reset result zero", result_data[63:0], 64'd0);

    // all eight lanes in one block: four paired flows
    for (int i = 0; i < 8; i++) ga[i] = 64'h0000_0040_0000_0000 + 64'(i) * 8;
    gp = 8'hFF;
    run_gather("same_block", 0, 4);

    // eight distinct blocks: eight single flows
    for (int i = 0; i < 8; i++) ga[i] = 64'h0000_0080_0000_0000 + 64'(i) * 64'h200 + 64'h18;
    gp = 8'hFF;
    run_gather("distinct_blocks", 0, 8);

    // partners far apart in lane order (R3)
    ga[0] = 64'h1000_0000; ga[5] = 64'h1000_0078;
    ga[1] = 64'h2000_0010; ga[6] = 64'h2000_0000;
    ga[2] = 64'h3000_0040; ga[3] = 64'h3000_0048;
    ga[4] = 64'h4000_0000; ga[7] = 64'h5000_0000;
    gp = 8'hFF;
    run_gather("scattered_pairs", 0, 5);

    // straddling a 128-byte boundary must not pair (R2)
    for (int i = 0; i < 8; i++) ga[i] = 64'h7000_0000 + 64'(i) * 64'h80 + 64'h78;
    ga[1] = 64'h7000_0080;
    gp = 8'b0000_0011;
    run_gather("boundary_R2", 0, 2);

    // empty predicate (R1, R8)
    gp = 8'h00;
    run_gather("empty_pred", 0, 0);

    // inactive lanes in the same block as active ones (R1)
    for (int i = 0; i < 8; i++) ga[i] = 64'h0000_0900_0000_0100 + 64'(i) * 8;
    gp = 8'b1010_0101;
    run_gather("masked_lanes", 0, 2);

    // three lanes in one block leave one single (R4)
    for (int i = 0; i < 8; i++) ga[i] = 64'hAB00_0000 + 64'(i) * 64'h1000;
    ga[2] = 64'hAB00_0008; ga[6] = 64'hAB00_0010;
    gp = 8'b0100_0101;
    run_gather("odd_block", 0, 2);

    // second request held during a busy gather is ignored (R9)
    for (int i = 0; i < 8; i++) ga[i] = 64'h0000_0C00_0000_0000 + 64'(i % 3) * 64'h80 + 64'(i) * 8;
    gp = 8'hFF;
    run_gather("busy_ignore", 1, -1);

    // random gathers drawn from a few shared blocks
    for (int t = 0; t < 60; t++) begin
      base = {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFFF_F000;
      for (int i = 0; i < 8; i++)
        ga[i] = base + 64'($urandom_range(0, 3)) * 64'h80 + 64'($urandom_range(0, 15)) * 8;
      gp = 8'($urandom());
      run_gather($sformatf("random_%0d", t), (t % 7) == 3, -1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule